// File: doc/BRIEF.md
# Read-latency and byte-mask data pipeline

This block is the data-path timing model for one byte-wide port of a synchronous DRAM. A read beat is launched by a read command or by a burst continuation. The block holds the byte that the array offers for that beat and returns it a programmable number of cycles later. It also raises the enable that lets the returned byte onto the shared data bus. A write beat is taken on the same edge as its command and passed straight to the array side.

The byte-mask input acts with two different delays. On the read side it blanks the beat that comes out two clock edges after the edge that sampled it. On the write side it blocks the beat sampled on that same edge. A precharge command ends a read burst. Beats already in flight still emerge, so the last driven beat depends on the programmed latency. A low clock-enable freezes the whole block for that edge. Address generation and command sequencing sit outside the block.

Top module: `dq_latency_pipe`

## Requirements
- R1: A read beat launched on an edge E with `cke` high sets `rd_valid` in the cycle after edge E+CL, counting only edges with `cke` high. CL is taken from `cas_lat`: codes 1, 2 and 3 give that latency, and code 0 acts as latency 1.
- R2: A read beat is launched by `cmd_rd`, or by `burst_act` while the last command seen was a read. Its byte is `arr_rdata` as sampled on the launch edge. Precedence on one edge is precharge, then write, then read.
- R3: `dqm` high on an edge D forces `dq_oe` low and `rd_data` to zero for the output that updates on edge D+2. On that masked beat `rd_valid` still marks the beat position.
- R4: A write beat is launched by `cmd_wr`, or by `burst_act` while the last command seen was a write. In the cycle after that edge, `wr_en` is high and `wr_out` equals `wr_data` from that edge. If `dqm` is high on the same edge, `wr_en` is low instead. `wr_out` is zero whenever `wr_en` is low.
- R5: `cmd_pre` launches no read beat on its own edge and stops burst continuation. After a precharge on edge P, no `rd_valid` appears from edge P+CL onward until a new `cmd_rd` is issued.
- R6: When a write beat is launched on the edge where a read beat falls due, `dq_oe` stays low for that beat. `dq_oe` and `wr_en` are never high together. A write command also ends read-burst continuation.
- R7: An edge with `cke` low is ignored. Commands, data and `dqm` are not taken, pipeline stages do not move, and every output holds its value.
- R8: After a synchronous reset, `rd_valid`, `dq_oe`, `wr_en`, `rd_data` and `wr_out` are all zero and no burst is open.
- R9: `dq_oe` is low whenever no read beat is due. `rd_data` is zero whenever `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low makes the edge a no-op |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| cmd_pre | input | 1 | Precharge command strobe |
| burst_act | input | 1 | Continue the open burst by one beat |
| cas_lat | input | 2 | Read latency code (0 acts as 1) |
| dqm | input | 1 | Byte mask |
| arr_rdata | input | 8 | Byte offered by the array for a launched read beat |
| wr_data | input | 8 | Write byte from the bus |
| rd_valid | output | 1 | A read beat position is due this cycle |
| rd_data | output | 8 | Returned read byte, zero when not driven |
| dq_oe | output | 1 | Data bus output enable |
| wr_en | output | 1 | Write beat accepted this cycle |
| wr_out | output | 8 | Write byte toward the array |

## Verification
The functions most likely to land in one cycle are a read beat reaching the bus and a write beat being accepted. The read beat might also have been masked two edges earlier. The bench opens a read burst and then cuts in with a write burst while earlier read beats are still in the latency pipe. It does this once without any mask and once with the mask raised three edges ahead of the write. It then checks that the bus enable stays low in each overlap cycle, that the write side still delivers its unmasked bytes, and that `rd_valid` keeps marking the beats whose drive was withheld. A cycle-indexed expectation table covers every latency code, including random mask patterns, precharge cut-offs and frozen edges.

// File: rtl/dqp_pkg.sv
package dqp_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_RD   = 2'd1,
    MODE_WR   = 2'd2
  } burst_mode_e;
endpackage

// File: rtl/dqp_cmd_track.sv
module dqp_cmd_track
  import dqp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic cmd_rd,
  input  logic cmd_wr,
  input  logic cmd_pre,
  input  logic burst_act,
  output logic rd_go,
  output logic wr_go
);
  burst_mode_e mode_q;

  // precedence: precharge > write > read
  always_comb begin
    rd_go = cke && !cmd_pre && !cmd_wr &&
            (cmd_rd || (burst_act && (mode_q == MODE_RD)));
    wr_go = cke && !cmd_pre &&
            (cmd_wr || (burst_act && (mode_q == MODE_WR)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_IDLE;
    end else if (cke) begin
      if (cmd_pre)     mode_q <= MODE_IDLE;
      else if (cmd_wr) mode_q <= MODE_WR;
      else if (cmd_rd) mode_q <= MODE_RD;
    end
  end

  AST_PRE_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
    (cke && cmd_pre) |=> (!rd_go || cmd_rd)); // R5

  AST_WR_ENDS_RD_BURST: assert property (@(posedge clk) disable iff (rst)
    (cke && cmd_wr && !cmd_pre) |=> (!rd_go || cmd_rd)); // R6
endmodule

// File: rtl/dqp_rd_pipe.sv
module dqp_rd_pipe #(
  parameter int DATA_W      = 8,
  parameter int MAX_CL      = 3,
  parameter int RD_MASK_LAT = 2,
  localparam int CLW        = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] rd_din,
  input  logic              wr_go,
  input  logic              dqm,
  input  logic [CLW-1:0]    cl_eff,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              dq_oe
);
  logic [MAX_CL-1:0]      vq;
  logic [DATA_W-1:0]      dq [MAX_CL];
  logic [RD_MASK_LAT-1:0] mq;
  logic                   due;
  logic [DATA_W-1:0]      due_d;
  logic                   drive;

  // valid tags and mask history carry reset; data stages do not
  always_ff @(posedge clk) begin
    if (rst) begin
      vq <= '0;
      mq <= '0;
    end else if (cke) begin
      vq <= MAX_CL'({vq, rd_go});
      mq <= RD_MASK_LAT'({mq, dqm});
    end
  end

  always_ff @(posedge clk) begin
    if (cke) dq[0] <= rd_din;
  end

  for (genvar g = 1; g < MAX_CL; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (cke) dq[g] <= dq[g-1];
    end
  end

  // tap the stage that matches the programmed latency
  always_comb begin
    due   = 1'b0;
    due_d = '0;
    for (int i = 0; i < MAX_CL; i++) begin
      if (cl_eff == CLW'(i + 1)) begin
        due   = vq[i];
        due_d = dq[i];
      end
    end
    drive = due && !mq[RD_MASK_LAT-1] && !wr_go;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      dq_oe    <= 1'b0;
      rd_data  <= '0;
    end else if (cke) begin
      rd_valid <= due;
      dq_oe    <= drive;
      rd_data  <= drive ? due_d : '0;
    end
  end

  AST_HOLD_ON_SUSPEND: assert property (@(posedge clk) disable iff (rst)
    !cke |=> ($stable(rd_valid) && $stable(dq_oe) && $stable(rd_data))); // R7
endmodule

// File: rtl/dqp_wr_stage.sv
module dqp_wr_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              wr_go,
  input  logic              dqm,
  input  logic [DATA_W-1:0] wr_din,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en  <= 1'b0;
      wr_out <= '0;
    end else if (cke) begin
      wr_en  <= wr_go && !dqm;
      wr_out <= (wr_go && !dqm) ? wr_din : '0;
    end
  end

  AST_WR_MASK_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
    (cke && dqm) |=> !wr_en); // R4
endmodule

// File: rtl/dq_latency_pipe.sv
module dq_latency_pipe #(
  parameter int DATA_W      = 8,
  parameter int MAX_CL      = 3,
  parameter int RD_MASK_LAT = 2,
  localparam int CLW        = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_pre,
  input  logic              burst_act,
  input  logic [CLW-1:0]    cas_lat,
  input  logic              dqm,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              dq_oe,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_out
);
  logic           rd_go;
  logic           wr_go;
  logic [CLW-1:0] cl_eff;
  logic [1:0]     age;

  always_comb begin
    if (cas_lat == '0)                 cl_eff = CLW'(1);
    else if (int'(cas_lat) > MAX_CL)   cl_eff = CLW'(MAX_CL);
    else                               cl_eff = cas_lat;
  end

  dqp_cmd_track u_cmd (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cmd_rd    (cmd_rd),
    .cmd_wr    (cmd_wr),
    .cmd_pre   (cmd_pre),
    .burst_act (burst_act),
    .rd_go     (rd_go),
    .wr_go     (wr_go)
  );

  dqp_rd_pipe #(
    .DATA_W      (DATA_W),
    .MAX_CL      (MAX_CL),
    .RD_MASK_LAT (RD_MASK_LAT)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .cke      (cke),
    .rd_go    (rd_go),
    .rd_din   (arr_rdata),
    .wr_go    (wr_go),
    .dqm      (dqm),
    .cl_eff   (cl_eff),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .dq_oe    (dq_oe)
  );

  dqp_wr_stage #(
    .DATA_W (DATA_W)
  ) u_wr (
    .clk    (clk),
    .rst    (rst),
    .cke    (cke),
    .wr_go  (wr_go),
    .dqm    (dqm),
    .wr_din (wr_data),
    .wr_en  (wr_en),
    .wr_out (wr_out)
  );

  // edges since reset, saturating; keeps $past windows inside reset history
  always_ff @(posedge clk) begin
    if (rst)               age <= '0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  AST_CL1_RETURN: assert property (@(posedge clk) disable iff (rst)
    (cke && cmd_rd && !cmd_wr && !cmd_pre && cas_lat == CLW'(1)) ##1 cke
    |=> rd_valid); // R1

  if (RD_MASK_LAT == 2) begin : g_rd_mask_chk
    AST_RD_MASK_TWO_LATER: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd3 && cke && $past(cke) && $past(cke, 2) && $past(dqm, 2))
      |=> !dq_oe); // R3
  end

  AST_WR_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
    (cke && cmd_wr && !cmd_pre && !dqm) |=> (wr_en && wr_out == $past(wr_data))); // R4

  AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (rst)
    !(dq_oe && wr_en)); // R6

  AST_WR_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (cke && cmd_wr && !cmd_pre) |=> !dq_oe); // R6
endmodule

// File: tb/sim_dq_latency_pipe.sv
module sim_dq_latency_pipe;
  localparam int PER  = 10;
  localparam int DW   = 8;
  localparam int NMAX = 4096;

  logic          clk = 1'b0;
  logic          rst, cke, cmd_rd, cmd_wr, cmd_pre, burst_act, dqm;
  logic [1:0]    cas_lat;
  logic [DW-1:0] arr_rdata, wr_data;
  logic          rd_valid, dq_oe, wr_en;
  logic [DW-1:0] rd_data, wr_out;

  dq_latency_pipe #(.DATA_W(DW), .MAX_CL(3), .RD_MASK_LAT(2)) u0 (
    .clk(clk), .rst(rst), .cke(cke), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_pre(cmd_pre), .burst_act(burst_act), .cas_lat(cas_lat), .dqm(dqm),
    .arr_rdata(arr_rdata), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .dq_oe(dq_oe), .wr_en(wr_en), .wr_out(wr_out)
  );

  always #(PER/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int n = 0;      // count of enabled edges since reset
  int mode = 0;   // 0 idle, 1 read burst, 2 write burst
  int cl = 1;     // programmed code
  int rv_seen = 0;
  bit ev [NMAX];  // read beat due at output after edge index
  bit em [NMAX];  // read mask applies
  bit ec [NMAX];  // write beat launched on that edge
  bit ew [NMAX];  // unmasked write beat
  logic [DW-1:0] ed  [NMAX];
  logic [DW-1:0] ewd [NMAX];

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at edge %0d: actual %0h expected %0h", tag, what, n, act, exp);
    end
  endtask

  // one clock edge: drive, advance, update expectation, compare outputs
  task automatic step(string tag, bit rd, bit wr, bit pre, bit bst, bit m, bit ck,
                      logic [DW-1:0] ad, logic [DW-1:0] wd);
    bit go_r, go_w, oe;
    int lat;
    @(negedge clk);
    cmd_rd = rd; cmd_wr = wr; cmd_pre = pre; burst_act = bst; dqm = m; cke = ck;
    arr_rdata = ad; wr_data = wd; cas_lat = 2'(cl);
    @(posedge clk);
    #(PER/4);
    if (ck) begin
      n++;
      lat  = (cl == 0) ? 1 : cl;
      go_r = !pre && !wr && (rd || (bst && mode == 1));
      go_w = !pre && (wr || (bst && mode == 2));
      if (pre)     mode = 0;
      else if (wr) mode = 2;
      else if (rd) mode = 1;
      if (go_r) begin ev[n+lat] = 1'b1; ed[n+lat] = ad; end
      if (m) em[n+2] = 1'b1;
      if (go_w) begin
        ec[n] = 1'b1;
        if (!m) begin ew[n] = 1'b1; ewd[n] = wd; end
      end
    end
    oe = ev[n] && !em[n] && !ec[n];
    if (rd_valid) rv_seen++;
    check(tag, "rd_valid", 32'(rd_valid), 32'(ev[n]));
    check(tag, "dq_oe",    32'(dq_oe),    32'(oe));
    check(tag, "rd_data",  32'(rd_data),  oe ? 32'(ed[n]) : 32'd0);
    check(tag, "wr_en",    32'(wr_en),    32'(ew[n]));
    check(tag, "wr_out",   32'(wr_out),   ew[n] ? 32'(ewd[n]) : 32'd0);
  endtask

  task automatic idle(string tag, int k);
    for (int i = 0; i < k; i++) step(tag, 0, 0, 0, 0, 0, 1, 8'h00, 8'h00);
  endtask

  task automatic t_reset();
    rst = 1'b1; cke = 1'b1; cmd_rd = 0; cmd_wr = 0; cmd_pre = 0; burst_act = 0;
    dqm = 0; cas_lat = 2'd1; arr_rdata = '0; wr_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #(PER/4);
    check("R8", "rd_valid", 32'(rd_valid), 0);
    check("R8", "dq_oe",    32'(dq_oe),    0);
    check("R8", "wr_en",    32'(wr_en),    0);
    check("R8", "rd_data",  32'(rd_data),  0);
    check("R8", "wr_out",   32'(wr_out),   0);
    // burst_act with no open burst must launch nothing (R2)
    step("R2", 0, 0, 0, 1, 0, 1, 8'h5A, 8'h00);
    idle("R9", 4);
  endtask

  task automatic t_latency();
    for (int c = 0; c < 4; c++) begin
      cl = c;
      step("R1", 1, 0, 0, 0, 0, 1, 8'(8'h10 + c), 8'h00);
      idle("R1", 5);
      step("R2", 1, 0, 0, 0, 0, 1, 8'(8'h20 + c), 8'h00);
      for (int b = 1; b < 4; b++) step("R2", 0, 0, 0, 1, 0, 1, 8'(8'h20 + 16*b + c), 8'h00);
      idle("R9", 5);
    end
  endtask

  task automatic t_mask();
    for (int c = 1; c < 4; c++) begin
      cl = c;
      step("R3", 1, 0, 0, 0, 1'($urandom), 1, 8'($urandom), 8'h00);
      for (int b = 1; b < 8; b++) step("R3", 0, 0, 0, 1, 1'($urandom), 1, 8'($urandom), 8'h00);
      for (int i = 0; i < 5; i++) step("R3", 0, 0, 0, 0, 1'($urandom), 1, 8'h00, 8'h00);
      idle("R3", 3);
    end
  endtask

  task automatic t_write();
    step("R4", 0, 1, 0, 0, 0, 1, 8'h00, 8'hA1);
    step("R4", 0, 0, 0, 1, 1, 1, 8'h00, 8'hA2);
    step("R4", 0, 0, 0, 1, 0, 1, 8'h00, 8'hA3);
    step("R4", 0, 0, 0, 1, 1, 1, 8'h00, 8'hA4);
    step("R4", 0, 1, 0, 0, 1, 1, 8'h00, 8'hA5);
    for (int b = 0; b < 6; b++) step("R4", 0, 0, 0, 1, 1'($urandom), 1, 8'h00, 8'($urandom));
    step("R5", 0, 0, 1, 0, 0, 1, 8'h00, 8'h00);
    step("R5", 0, 0, 0, 1, 0, 1, 8'h00, 8'hEE);
    idle("R4", 3);
  endtask

  task automatic t_precharge();
    for (int c = 1; c < 4; c++) begin
      cl = c;
      rv_seen = 0;
      step("R5", 1, 0, 0, 0, 0, 1, 8'hC1, 8'h00);
      step("R5", 0, 0, 0, 1, 0, 1, 8'hC2, 8'h00);
      step("R5", 0, 0, 0, 1, 0, 1, 8'hC3, 8'h00);
      step("R5", 1, 0, 1, 1, 0, 1, 8'hC4, 8'h00);
      for (int b = 0; b < 3; b++) step("R5", 0, 0, 0, 1, 0, 1, 8'hC5, 8'h00);
      idle("R5", 3);
      check("R5", "beats before cut-off", 32'(rv_seen), 32'd3);
    end
  endtask

  task automatic t_clash();
    cl = 2;
    // write cuts in with no mask: bus enable must stay low on overlap
    step("R6", 1, 0, 0, 0, 0, 1, 8'hD1, 8'h00);
    for (int b = 0; b < 3; b++) step("R6", 0, 0, 0, 1, 0, 1, 8'(8'hD2 + b), 8'h00);
    step("R6", 0, 1, 0, 0, 0, 1, 8'h00, 8'h71);
    for (int b = 0; b < 3; b++) step("R6", 0, 0, 0, 1, 0, 1, 8'h00, 8'(8'h72 + b));
    step("R5", 0, 0, 1, 0, 0, 1, 8'h00, 8'h00);
    idle("R6", 3);
    // same with the mask raised three edges before the write
    step("R6", 1, 0, 0, 0, 0, 1, 8'hE1, 8'h00);
    step("R6", 0, 0, 0, 1, 1, 1, 8'hE2, 8'h00);
    step("R6", 0, 0, 0, 1, 1, 1, 8'hE3, 8'h00);
    step("R6", 0, 0, 0, 1, 1, 1, 8'hE4, 8'h00);
    step("R6", 0, 1, 0, 0, 0, 1, 8'h00, 8'h81);
    step("R6", 0, 0, 0, 1, 0, 1, 8'h00, 8'h82);
    step("R5", 0, 0, 1, 0, 0, 1, 8'h00, 8'h00);
    idle("R6", 3);
  endtask

  task automatic t_suspend();
    cl = 3;
    step("R7", 1, 0, 0, 0, 0, 1, 8'hB1, 8'h00);
    step("R7", 0, 0, 0, 1, 0, 1, 8'hB2, 8'h00);
    step("R7", 1, 1, 1, 1, 1, 0, 8'hFF, 8'hFF);
    step("R7", 0, 1, 0, 1, 1, 0, 8'hFE, 8'hFE);
    step("R7", 0, 0, 0, 1, 0, 1, 8'hB3, 8'h00);
    step("R7", 0, 0, 0, 1, 0, 1, 8'hB4, 8'h00);
    step("R7", 0, 0, 0, 0, 0, 1, 8'h00, 8'h00);
    step("R7", 0, 0, 0, 0, 1, 0, 8'h00, 8'h00);
    step("R7", 0, 0, 0, 0, 0, 1, 8'h00, 8'h00);
    step("R7", 1, 0, 0, 0, 0, 0, 8'h99, 8'h00);
    idle("R7", 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_mask();
    t_write();
    t_precharge();
    t_clash();
    t_suspend();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule